// File: doc/BRIEF.md
# Timer Capture/Compare Event Channel

This block is one event channel that works beside two free-running timers, called timer A and timer B. A control register picks the timer, the operating mode, and either the input edge to capture or the action to take on a match. In capture mode a synchronized input pin is watched for the chosen edge. The chosen timer's value is then stored in a visible time register. A second capture waits in a one-entry buffer behind it.

In compare mode the same time register holds a target time. When the chosen timer first equals that target, the channel acts on its output pin: it can set, clear or toggle it. The same match can also pulse a reset request to the chosen timer and a start request to an A/D converter.

A second compare source (the peer) shares the output pin with equal standing. Its set, clear and toggle requests are merged with the channel's own requests each cycle. A one-cycle event interrupt marks every capture and every compare match. A separate overrun interrupt marks a capture that arrives while both storage stages are full.

Top module: `evt_channel`

## Requirements
- R1: After reset, pin_out, time_q, ovr_pend, evt_irq, ovr_irq, tmr_a_rst, tmr_b_rst and adc_start are all 0.
- R2: The control word is ctl_wdata, loaded when ctl_wr is high. Bit 0 selects compare mode (1) or capture mode (0), and bit 1 selects timer B (1) or timer A (0). In capture mode, bits 3:2 choose the edge: 00 none, 01 falling, 10 rising, 11 both. A chosen edge of pin_in, after a two-flop synchronizer, stores the selected timer's value. That value appears on time_q three clock edges after pin_in changes.
- R3: A capture that arrives while the time register holds an unread value goes to the buffer instead. A read pulse (time_rd) moves the buffered value into time_q and empties the buffer. The value read is the time_q seen in the cycle of the pulse.
- R4: A capture that arrives while both stages are full raises a one-cycle ovr_irq and sets ovr_pend. Bit 4 of the control word picks the overwrite policy: when it is 1 the new value replaces the buffered one, and when it is 0 the new value is discarded.
- R5: A read clears ovr_pend. A read with an empty buffer leaves the time register empty, so the next capture lands in time_q.
- R6: In compare mode, bits 3:2 of the control word choose the pin action on a match: 00 none, 01 set, 10 clear, 11 toggle. A match occurs on the first cycle in which the selected timer equals time_q. The pin is updated one edge after the match cycle.
- R7: A compare fires once and is then disarmed. A write to the time register (time_wr) re-arms it. When bit 7 of the control word is 1, the channel stays armed and fires again each time equality begins anew.
- R8: On a match, bit 5 of the control word pulses tmr_a_rst or tmr_b_rst (for the selected timer only), and bit 6 pulses adc_start. Each pulse lasts one cycle.
- R9: Own and peer requests act on the shared pin in the same cycle. If set and clear are both requested, the pin toggles. A toggle request from either source then inverts the result once. With no request, the pin holds.
- R10: evt_irq is a one-cycle pulse, one edge after each capture or compare match.
- R11: When a read and a capture fall in the same cycle, the read is applied first. The capture then goes into the freed stage, and no overrun is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_wr | input | 1 | Load control word |
| ctl_wdata | input | 8 | Control word |
| time_wr | input | 1 | Write time register (re-arms compare) |
| time_wdata | input | TW | Time register write data |
| time_rd | input | 1 | Read strobe, pops the capture buffer |
| time_q | output | TW | Visible time register |
| ovr_pend | output | 1 | Overrun seen since last read |
| tmr_a | input | TW | Timer A value |
| tmr_b | input | TW | Timer B value |
| pin_in | input | 1 | Capture input pin (asynchronous) |
| peer_set | input | 1 | Peer source set request |
| peer_clr | input | 1 | Peer source clear request |
| peer_tgl | input | 1 | Peer source toggle request |
| pin_out | output | 1 | Shared output pin state |
| tmr_a_rst | output | 1 | Reset request to timer A |
| tmr_b_rst | output | 1 | Reset request to timer B |
| adc_start | output | 1 | A/D start pulse |
| evt_irq | output | 1 | Event interrupt pulse |
| ovr_irq | output | 1 | Capture overrun interrupt pulse |

## Verification
Two pairs of functions can land in the same clock edge.

The first pair is a software read and a new capture. The bench lines up the read strobe with the exact edge on which a synchronized pin edge is captured. It does this once with only the time register full and once with both stages full. It then checks that time_q shows the popped value and that the buffer holds the new one, with no overrun.

The second pair is the channel's own compare action and the peer's pin requests. A seeded random run sets the timer equal to the target, or one away from it, while driving random peer requests. Every pin value is compared with a bench model of the merge rules. Directed cases cover simultaneous set and clear with and without a toggle.

// File: rtl/evt_pkg.sv
package evt_pkg;

  // control word, bit 7 down to bit 0
  typedef struct packed {
    logic       rearm;     // 7
    logic       adc_en;    // 6
    logic       trst_en;   // 5
    logic       ovw;       // 4
    logic [1:0] sel2;      // 3:2 edge (capture) or action (compare)
    logic       tsel;      // 1
    logic       cmp_mode;  // 0
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  localparam logic [1:0] EDGE_FALL = 2'b01;
  localparam logic [1:0] EDGE_RISE = 2'b10;
  localparam logic [1:0] ACT_SET   = 2'b01;
  localparam logic [1:0] ACT_CLR   = 2'b10;
  localparam logic [1:0] ACT_TGL   = 2'b11;

  function automatic logic edge_hit(input logic [1:0] sel, input logic rise, input logic fall);
    return (sel[1] & rise) | (sel[0] & fall);
  endfunction

  // merged request rule for the shared pin
  function automatic logic pin_next(input logic cur, input logic s, input logic c, input logic t);
    logic base;
    if (s && c)  base = ~cur;
    else if (s)  base = 1'b1;
    else if (c)  base = 1'b0;
    else         base = cur;
    return t ? ~base : base;
  endfunction

endpackage

// File: rtl/evt_edge_sync.sv
module evt_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic rise,
  output logic fall
);
  logic [2:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], pin_in};
  end

  assign rise = sh[1] & ~sh[2];
  assign fall = ~sh[1] & sh[2];
endmodule

// File: rtl/evt_capture_q.sv
module evt_capture_q #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [TW-1:0] cap_val,
  input  logic          rd,
  input  logic          wr,
  input  logic [TW-1:0] wdata,
  input  logic          ovw,
  output logic [TW-1:0] time_q,
  output logic          tfull,
  output logic          bfull,
  output logic          ovr_evt,
  output logic          ovr_pend
);
  logic [TW-1:0] buf_r, t_n, b_n;
  logic          tf_n, bf_n, op_n;

  always_comb begin
    t_n     = time_q;
    b_n     = buf_r;
    tf_n    = tfull;
    bf_n    = bfull;
    op_n    = ovr_pend;
    ovr_evt = 1'b0;
    // read acts first
    if (rd) begin
      op_n = 1'b0;
      if (bfull) begin
        t_n  = buf_r;
        bf_n = 1'b0;
      end else begin
        tf_n = 1'b0;
      end
    end
    if (cap_en) begin
      if (!tf_n) begin
        t_n  = cap_val;
        tf_n = 1'b1;
      end else if (!bf_n) begin
        b_n  = cap_val;
        bf_n = 1'b1;
      end else begin
        ovr_evt = 1'b1;
        op_n    = 1'b1;
        if (ovw) b_n = cap_val;
      end
    end
    if (wr) t_n = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q   <= '0;
      buf_r    <= '0;
      tfull    <= 1'b0;
      bfull    <= 1'b0;
      ovr_pend <= 1'b0;
    end else begin
      time_q   <= t_n;
      buf_r    <= b_n;
      tfull    <= tf_n;
      bfull    <= bf_n;
      ovr_pend <= op_n;
    end
  end
endmodule

// File: rtl/evt_compare.sv
module evt_compare #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [TW-1:0] tmr_val,
  input  logic [TW-1:0] evt_time,
  input  logic          load,
  input  logic          rearm,
  output logic          fire
);
  logic armed, eq_d, eq;

  assign eq   = (tmr_val == evt_time);
  assign fire = en & armed & eq & ~eq_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      eq_d  <= 1'b0;
    end else begin
      eq_d <= load ? 1'b0 : eq;
      if (load)                armed <= 1'b1;
      else if (fire && !rearm) armed <= 1'b0;
    end
  end
endmodule

// File: rtl/evt_pin_mux.sv
module evt_pin_mux
  import evt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic own_set,
  input  logic own_clr,
  input  logic own_tgl,
  input  logic peer_set,
  input  logic peer_clr,
  input  logic peer_tgl,
  output logic pin_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_out <= 1'b0;
    else pin_out <= pin_next(pin_out, own_set | peer_set, own_clr | peer_clr, own_tgl | peer_tgl);
  end
endmodule

// File: rtl/evt_channel.sv
module evt_channel
  import evt_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             time_wr,
  input  logic [TW-1:0]    time_wdata,
  input  logic             time_rd,
  output logic [TW-1:0]    time_q,
  output logic             ovr_pend,
  input  logic [TW-1:0]    tmr_a,
  input  logic [TW-1:0]    tmr_b,
  input  logic             pin_in,
  input  logic             peer_set,
  input  logic             peer_clr,
  input  logic             peer_tgl,
  output logic             pin_out,
  output logic             tmr_a_rst,
  output logic             tmr_b_rst,
  output logic             adc_start,
  output logic             evt_irq,
  output logic             ovr_irq
);
  ctl_t          ctl;
  logic [TW-1:0] tmr_sel;
  logic          rise, fall, cap_evt, cmp_fire, ovr_evt, tfull, bfull;
  logic          own_set, own_clr, own_tgl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl <= '0;
    else if (ctl_wr) ctl <= ctl_t'(ctl_wdata);
  end

  assign tmr_sel = ctl.tsel ? tmr_b : tmr_a;

  evt_edge_sync u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .rise(rise), .fall(fall)
  );

  assign cap_evt = ~ctl.cmp_mode & edge_hit(ctl.sel2, rise, fall);

  evt_capture_q #(.TW(TW)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_evt), .cap_val(tmr_sel),
    .rd(time_rd), .wr(time_wr), .wdata(time_wdata), .ovw(ctl.ovw),
    .time_q(time_q), .tfull(tfull), .bfull(bfull),
    .ovr_evt(ovr_evt), .ovr_pend(ovr_pend)
  );

  evt_compare #(.TW(TW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .en(ctl.cmp_mode), .tmr_val(tmr_sel),
    .evt_time(time_q), .load(time_wr), .rearm(ctl.rearm), .fire(cmp_fire)
  );

  assign own_set = cmp_fire & (ctl.sel2 == ACT_SET);
  assign own_clr = cmp_fire & (ctl.sel2 == ACT_CLR);
  assign own_tgl = cmp_fire & (ctl.sel2 == ACT_TGL);

  evt_pin_mux u_pin (
    .clk(clk), .rst_n(rst_n),
    .own_set(own_set), .own_clr(own_clr), .own_tgl(own_tgl),
    .peer_set(peer_set), .peer_clr(peer_clr), .peer_tgl(peer_tgl),
    .pin_out(pin_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_irq   <= 1'b0;
      ovr_irq   <= 1'b0;
      tmr_a_rst <= 1'b0;
      tmr_b_rst <= 1'b0;
      adc_start <= 1'b0;
    end else begin
      evt_irq   <= cap_evt | cmp_fire;
      ovr_irq   <= ovr_evt;
      tmr_a_rst <= cmp_fire & ctl.trst_en & ~ctl.tsel;
      tmr_b_rst <= cmp_fire & ctl.trst_en & ctl.tsel;
      adc_start <= cmp_fire & ctl.adc_en;
    end
  end
endmodule

// File: rtl/evt_channel_chk.sv
module evt_channel_chk (
  input logic clk,
  input logic rst_n,
  input logic cap_evt,
  input logic cmp_fire,
  input logic ovr_evt,
  input logic tfull,
  input logic bfull,
  input logic time_rd,
  input logic ovr_pend,
  input logic ovr_irq,
  input logic evt_irq,
  input logic own_set,
  input logic own_clr,
  input logic own_tgl,
  input logic peer_set,
  input logic peer_clr,
  input logic peer_tgl,
  input logic pin_out,
  input logic tmr_a_rst,
  input logic tmr_b_rst
);
  assert_irq_follows_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_irq == $past(cap_evt | cmp_fire));

  assert_ovr_only_when_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_irq |-> ($past(tfull) && $past(bfull)));

  assert_ovr_sets_pend_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> ovr_pend);

  assert_read_clears_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
    time_rd |=> !ovr_pend);

  assert_read_no_overrun_R11: assert property (@(posedge clk) disable iff (!rst_n)
    time_rd |-> !ovr_evt);

  assert_fire_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fire |=> !cmp_fire);

  assert_pin_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(own_set | own_clr | own_tgl | peer_set | peer_clr | peer_tgl) |=> $stable(pin_out));

  assert_one_timer_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(tmr_a_rst && tmr_b_rst));
endmodule

bind evt_channel evt_channel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cap_evt(cap_evt), .cmp_fire(cmp_fire),
  .ovr_evt(ovr_evt), .tfull(tfull), .bfull(bfull), .time_rd(time_rd),
  .ovr_pend(ovr_pend), .ovr_irq(ovr_irq), .evt_irq(evt_irq),
  .own_set(own_set), .own_clr(own_clr), .own_tgl(own_tgl),
  .peer_set(peer_set), .peer_clr(peer_clr), .peer_tgl(peer_tgl),
  .pin_out(pin_out), .tmr_a_rst(tmr_a_rst), .tmr_b_rst(tmr_b_rst)
);

// File: tb/evt_channel_bench.sv
module evt_channel_bench;
  localparam int TW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic time_wr = 1'b0;
  logic [TW-1:0] time_wdata = '0;
  logic time_rd = 1'b0;
  logic [TW-1:0] time_q;
  logic ovr_pend;
  logic [TW-1:0] tmr_a = '0, tmr_b = '0;
  logic pin_in = 1'b0;
  logic peer_set = 1'b0, peer_clr = 1'b0, peer_tgl = 1'b0;
  logic pin_out, tmr_a_rst, tmr_b_rst, adc_start, evt_irq, ovr_irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  evt_channel #(.TW(TW)) u_evt_channel (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .time_wr(time_wr), .time_wdata(time_wdata), .time_rd(time_rd),
    .time_q(time_q), .ovr_pend(ovr_pend), .tmr_a(tmr_a), .tmr_b(tmr_b),
    .pin_in(pin_in), .peer_set(peer_set), .peer_clr(peer_clr), .peer_tgl(peer_tgl),
    .pin_out(pin_out), .tmr_a_rst(tmr_a_rst), .tmr_b_rst(tmr_b_rst),
    .adc_start(adc_start), .evt_irq(evt_irq), .ovr_irq(ovr_irq)
  );

  task automatic check(input int act, input int exp, input string tag);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // bench restatement of the shared pin rule
  function automatic logic model_pin(logic cur, logic s, logic c, logic t);
    logic r;
    case ({s, c})
      2'b11:   r = !cur;
      2'b10:   r = 1'b1;
      2'b01:   r = 1'b0;
      default: r = cur;
    endcase
    if (t) r = !r;
    return r;
  endfunction

  task automatic wr_ctl(input logic [7:0] v);
    ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic wr_time(input logic [TW-1:0] v);
    time_wr = 1'b1; time_wdata = v;
    @(negedge clk);
    time_wr = 1'b0;
  endtask

  task automatic do_read(output logic [TW-1:0] v);
    v = time_q;
    time_rd = 1'b1;
    @(negedge clk);
    time_rd = 1'b0;
  endtask

  task automatic edge_to(input logic lvl, output logic i3, output logic o3, output logic i4);
    pin_in = lvl;
    repeat (3) @(negedge clk);
    i3 = evt_irq; o3 = ovr_irq;
    @(negedge clk);
    i4 = evt_irq;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic i3, o3, i4;
    logic [TW-1:0] v;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(pin_out, 0, "R1 pin_out");
    check(time_q, 0, "R1 time_q");
    check(ovr_pend, 0, "R1 ovr_pend");
    check(evt_irq | ovr_irq | tmr_a_rst | tmr_b_rst | adc_start, 0, "R1 pulses");

    // capture, rising, timer A
    tmr_a = 16'd100; tmr_b = 16'd200;
    wr_ctl(8'h08);
    edge_to(1'b1, i3, o3, i4);
    check(i3, 1, "R10 irq on capture");
    check(i4, 0, "R10 irq one cycle");
    check(time_q, 100, "R2 rising capture A");
    edge_to(1'b0, i3, o3, i4);
    check(i3, 0, "R2 falling ignored in rising mode");
    check(time_q, 100, "R2 time unchanged");
    // timer B, goes to buffer
    wr_ctl(8'h0A);
    edge_to(1'b1, i3, o3, i4);
    check(time_q, 100, "R3 visible value held");
    do_read(v);
    check(v, 100, "R3 read value");
    check(time_q, 200, "R3 buffer popped from timer B");
    do_read(v);
    check(v, 200, "R3 second read");

    // both edges, no overwrite
    wr_ctl(8'h0C);
    tmr_a = 16'd1; edge_to(1'b0, i3, o3, i4);
    check(i3, 1, "R2 falling in both mode");
    tmr_a = 16'd2; edge_to(1'b1, i3, o3, i4);
    tmr_a = 16'd3; edge_to(1'b0, i3, o3, i4);
    check(o3, 1, "R4 overrun pulse");
    check(ovr_pend, 1, "R4 overrun pending");
    do_read(v);
    check(v, 1, "R4 first read");
    check(time_q, 2, "R4 new value discarded");
    check(ovr_pend, 0, "R5 read clears overrun");
    do_read(v);

    // overwrite
    wr_ctl(8'h1C);
    tmr_a = 16'd4; edge_to(1'b1, i3, o3, i4);
    check(time_q, 4, "R5 empty after read, capture lands in time");
    tmr_a = 16'd5; edge_to(1'b0, i3, o3, i4);
    tmr_a = 16'd6; edge_to(1'b1, i3, o3, i4);
    check(o3, 1, "R4 overrun with overwrite");
    do_read(v);
    check(time_q, 6, "R4 buffer overwritten");
    do_read(v);

    // R11 read and capture in the same cycle
    tmr_a = 16'd7; edge_to(1'b0, i3, o3, i4);
    tmr_a = 16'd8; pin_in = 1'b1;
    repeat (2) @(negedge clk);
    do_read(v);
    check(v, 7, "R11 read value");
    check(evt_irq, 1, "R11 capture accepted");
    check(ovr_irq, 0, "R11 no overrun (time only)");
    check(time_q, 8, "R11 capture into freed time register");
    tmr_a = 16'd9; edge_to(1'b0, i3, o3, i4);
    tmr_a = 16'd10; pin_in = 1'b1;
    repeat (2) @(negedge clk);
    do_read(v);
    check(v, 8, "R11 read value both full");
    check(ovr_irq, 0, "R11 no overrun (both full)");
    check(time_q, 9, "R11 buffer popped");
    do_read(v);
    check(time_q, 10, "R11 capture kept in buffer");
    do_read(v);

    // compare, set action on timer A
    wr_ctl(8'h05);
    tmr_a = 16'd0;
    wr_time(16'd50);
    tmr_a = 16'd49; @(negedge clk);
    check(evt_irq, 0, "R6 no match");
    tmr_a = 16'd50; @(negedge clk);
    check(evt_irq, 1, "R6 match irq");
    check(pin_out, 1, "R6 set action");
    @(negedge clk);
    check(evt_irq, 0, "R7 fires once while equal");
    tmr_a = 16'd51; @(negedge clk);
    tmr_a = 16'd50; @(negedge clk);
    check(evt_irq, 0, "R7 disarmed after fire");
    wr_ctl(8'h09);
    tmr_a = 16'd0;
    wr_time(16'd50);
    tmr_a = 16'd50; @(negedge clk);
    check(evt_irq, 1, "R7 re-armed by write");
    check(pin_out, 0, "R6 clear action");
    // toggle with rearm
    wr_ctl(8'h8D);
    tmr_a = 16'd0; wr_time(16'd50);
    tmr_a = 16'd50; @(negedge clk);
    check(pin_out, 1, "R6 toggle action");
    tmr_a = 16'd51; @(negedge clk);
    tmr_a = 16'd50; @(negedge clk);
    check(evt_irq, 1, "R7 rearm bit fires again");
    check(pin_out, 0, "R6 toggle back");

    // timer reset and A/D start on timer B
    wr_ctl(8'h63);
    tmr_b = 16'd0; wr_time(16'd77);
    tmr_b = 16'd77; @(negedge clk);
    check(tmr_b_rst, 1, "R8 timer B reset");
    check(tmr_a_rst, 0, "R8 timer A untouched");
    check(adc_start, 1, "R8 A/D start");
    check(pin_out, 0, "R6 action none");
    @(negedge clk);
    check(tmr_b_rst | adc_start, 0, "R8 single pulse");

    // R9 directed peer cases
    peer_set = 1'b1; peer_clr = 1'b1; @(negedge clk);
    peer_set = 1'b0; peer_clr = 1'b0;
    check(pin_out, 1, "R9 set and clear toggles");
    peer_set = 1'b1; peer_clr = 1'b1; peer_tgl = 1'b1; @(negedge clk);
    peer_set = 1'b0; peer_clr = 1'b0; peer_tgl = 1'b0;
    check(pin_out, 1, "R9 set+clear+toggle holds");
    @(negedge clk);
    check(pin_out, 1, "R9 no request holds");

    // R9 random: own compare actions merged with random peer requests
    for (int act = 1; act < 4; act++) begin
      logic armed_m, eqd_m, pin_m, irq_m;
      logic [TW-1:0] evt_t;
      evt_t = TW'(16'h0300 + act);
      wr_ctl(8'h81 | 8'(act << 2));
      tmr_a = evt_t + 16'd2;
      wr_time(evt_t);
      armed_m = 1'b1; eqd_m = 1'b0; pin_m = pin_out; irq_m = 1'b0;
      for (int i = 0; i < 80; i++) begin
        logic fire, s, c, t, eq;
        if (i > 0) begin
          check(pin_out, pin_m, "R9 random shared pin");
          check(evt_irq, irq_m, "R10 random compare irq");
        end
        tmr_a = ($urandom % 2 == 0) ? evt_t : evt_t + 16'd1;
        peer_set = ($urandom % 4 == 0);
        peer_clr = ($urandom % 4 == 0);
        peer_tgl = ($urandom % 4 == 0);
        eq = (tmr_a == evt_t);
        fire = armed_m && eq && !eqd_m;
        eqd_m = eq;
        s = peer_set | (fire && act == 1);
        c = peer_clr | (fire && act == 2);
        t = peer_tgl | (fire && act == 3);
        pin_m = model_pin(pin_m, s, c, t);
        irq_m = fire;
        @(negedge clk);
      end
      check(pin_out, pin_m, "R9 random final");
      peer_set = 1'b0; peer_clr = 1'b0; peer_tgl = 1'b0;
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule